// File: doc/BRIEF.md
# SPI Transceiver with Master and Slave Modes

This block is an 8-bit full-duplex serial peripheral interface engine for a bus-attached peripheral slot. One configuration bit picks whether it generates the serial clock (master) or follows a clock from outside (slave). Further bits choose the clock's idle level, the edge on which data is captured, and whether the least or most significant bit goes first. In master mode a divider derives the serial clock from the system clock.

Software uses four byte-wide locations. Writing the data location as an enabled master starts a transfer. In slave mode the same write preloads the byte to send on the next select. Reading the data location returns the last received byte and clears the transfer-complete flag.

The slave-select pin takes one of four roles. It can be ignored as general-purpose I/O. It can be watched for a mode fault. It can be driven automatically around each transfer. In slave mode it is always the select input. The role is set by the master bit and two further bits. All pins come out as separate input, output and output-enable signals. Slave-side pin inputs pass through two-flop synchronizers.

Top module: `spi_xcvr`

## Requirements
- R1: Address 2 (DATA) written while CFG bit0 (enable) and bit1 (master) are 1 and no transfer is running starts a transfer. 8 bits of `wdata_i` are shifted out on `mosi_o` while 8 bits from `miso_i` are shifted in. A later read of DATA returns the received byte.
- R2: CFG bit2 (polarity) sets the level `sck_o` rests at between transfers: 0 rests low, 1 rests high. Each master transfer produces exactly 16 `sck_o` transitions and returns to that level.
- R3: With CFG bit3 (phase) at 0, each bit is valid before and captured on the leading (away-from-rest) clock edge, and changes on the trailing edge. With phase 1, each bit changes on the leading edge and is captured on the trailing edge.
- R4: CFG bit4 (order) at 0 sends and receives the most significant bit first; at 1, the least significant bit first.
- R5: CFG2 bits [4:3] (div) set the master half-period to 4<<div system clock cycles. The first `sck_o` edge comes one half-period after the transfer starts, and every later edge follows the previous one by one half-period.
- R6: With CFG2 bit0 (fault enable) and bit1 (select drive) both 1 in master mode, `ss_oe_o` is 1. `ss_o` goes low in the cycle after the start and stays low across every clock edge. It returns high once the transfer ends.
- R7: In master mode with fault enable 0, `ss_oe_o` is 0 and a low level on `ss_i` neither raises a fault nor disturbs the transfer.
- R8: In master mode with fault enable 1 and select drive 0, a low level on `ss_i` sets STAT bit5 (fault) and clears CFG bit1 (master). It aborts the transfer and sets `sck_oe_o` and `mosi_oe_o` to 0.
- R9: In slave mode, `ss_i` low selects the block whatever the fault enable and select drive bits are. The block then drives `miso_o` (with `miso_oe_o` = 1) from the byte last written to DATA, shifts in `mosi_i` on the edges of `sck_i`, and leaves `sck_oe_o` at 0. `miso_oe_o` is 0 while `ss_i` is high.
- R10: After reset every location reads 0 and all output enables are 0. Unimplemented bits read 0: CFG bits 7:5, and CFG2 bits 7, 6, 5 and 2.
- R11: STAT bit7 (done) is set when the eighth bit has been captured and is cleared by a read of DATA. STAT bit0 (busy) reads 1 while a master transfer runs.
- R12: The fault flag stays set until STAT is written with bit5 at 1. Writing STAT with bit5 at 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Location: 0 CFG, 1 CFG2, 2 DATA, 3 STAT |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effect on DATA only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed location |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out |
| mosi_oe_o | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in line out (slave) |
| miso_oe_o | output | 1 | Master-in output enable |
| ss_i | input | 1 | Slave-select pin in |
| ss_o | output | 1 | Slave-select pin out |
| ss_oe_o | output | 1 | Slave-select output enable |

## Verification
A wrong divider or edge-counter state shows at the pins within one half-period. The bench sees it as a misplaced `sck_o` edge or the wrong number of edges. A phase or bit-order fault puts a wrong bit on `mosi_o` at the first capture edge, and the bench's slave model compares every captured bit there. A fault in the receive path shows only once the transfer ends, when the byte read back from DATA is wrong. Mode-fault handling shows within a few cycles of `ss_i` falling: the output enables drop and the master bit clears.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DW = 8;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CFG2 = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL
  } mstate_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int            W   = 1,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_clk_ctrl.sv
module spi_clk_ctrl
  import spi_pkg::*;
#(
  parameter int DIV_W   = 2,
  parameter int MIN_LOG = 2,
  parameter int EDGES   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             edge_o,
  output logic             lead_o,
  output logic             phase_o,
  output logic             active_o
);
  localparam int HC_W = MIN_LOG + (1 << DIV_W);
  localparam int EC_W = $clog2(EDGES + 1);

  mstate_e          st_q;
  logic [HC_W-1:0]  cnt_q, half_m1;
  logic [EC_W-1:0]  edg_q;
  logic             phase_q;
  logic             tick;

  assign half_m1 = HC_W'((32'd1 << (MIN_LOG + int'(div_sel_i))) - 32'd1);
  assign tick    = (st_q != ST_IDLE) && (cnt_q == '0);
  assign edge_o  = tick && (st_q == ST_LEAD || st_q == ST_RUN);
  assign lead_o  = !phase_q;
  assign phase_o = phase_q;
  assign active_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      edg_q   <= '0;
      phase_q <= 1'b0;
    end else if (abort_i) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      edg_q   <= '0;
      phase_q <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_q  <= ST_LEAD;
        cnt_q <= half_m1;
        edg_q <= '0;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - HC_W'(1);
    end else begin
      cnt_q <= half_m1;
      unique case (st_q)
        ST_LEAD: begin
          phase_q <= ~phase_q;
          edg_q   <= EC_W'(1);
          st_q    <= ST_RUN;
        end
        ST_RUN: begin
          phase_q <= ~phase_q;
          edg_q   <= edg_q + EC_W'(1);
          if (edg_q == EC_W'(EDGES - 1)) st_q <= ST_TAIL;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_PHASE_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !phase_q); // R2
  AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edg_q <= EC_W'(EDGES)); // R5
  AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !abort_i) |=> $stable(phase_q)); // R5
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] tx_i,
  input  logic         lsb_i,
  input  logic         sample_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic         done_o,
  output logic [W-1:0] rx_next_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  tx_q, rx_q;
  logic [CW-1:0] cnt_q;

  assign sdo_o     = lsb_i ? tx_q[0] : tx_q[W-1];
  assign rx_next_o = lsb_i ? {sdi_i, rx_q[W-1:1]} : {rx_q[W-2:0], sdi_i};
  assign done_o    = sample_i && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      tx_q  <= tx_i;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (sample_i && cnt_q < CW'(W)) begin
        rx_q  <= rx_next_o;
        cnt_q <= cnt_q + CW'(1);
      end
      // first leading edge in phase-1 only presents bit 0, already on the line
      if (shift_i && cnt_q != '0 && cnt_q < CW'(W))
        tx_q <= lsb_i ? (tx_q >> 1) : (tx_q << 1);
    end
  end

  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> !done_o); // R11
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_pkg::*;
#(
  parameter int DIV_W   = 2,
  parameter int MIN_LOG = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe_o,
  input  logic        mosi_i,
  output logic        mosi_o,
  output logic        mosi_oe_o,
  input  logic        miso_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  input  logic        ss_i,
  output logic        ss_o,
  output logic        ss_oe_o
);
  localparam int EDGES = 2 * DW;

  logic en_q, mst_q, cpol_q, cpha_q, lsb_q, modf_en_q, ssoe_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0] tx_hold_q, rx_buf_q, rx_next;
  logic done_q, modf_q;

  logic ss_s, sck_s, mosi_s, miso_s;
  logic s_sel_q, sck_s_q;
  logic m_edge, m_lead, m_phase, m_active;
  logic s_sel, s_start, s_edge, s_lead;
  logic edge_ev, lead_ev, sample_ev, shift_ev;
  logic wr_data, rd_data, m_start, modf_hit, shift_done, sdo, busy;

  spi_sync #(.W(4), .RST(4'b1000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_i, sck_i, mosi_i, miso_i}),
    .q_o    ({ss_s, sck_s, mosi_s, miso_s})
  );

  assign wr_data  = wr_i && (addr_i == ADDR_DATA);
  assign rd_data  = rd_i && (addr_i == ADDR_DATA);
  assign modf_hit = en_q && mst_q && modf_en_q && !ssoe_q && !ss_s;
  assign m_start  = wr_data && en_q && mst_q && !m_active && !modf_hit;

  spi_clk_ctrl #(.DIV_W(DIV_W), .MIN_LOG(MIN_LOG), .EDGES(EDGES)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (m_start),
    .abort_i   (modf_hit || !(en_q && mst_q)),
    .div_sel_i (div_q),
    .edge_o    (m_edge),
    .lead_o    (m_lead),
    .phase_o   (m_phase),
    .active_o  (m_active)
  );

  // slave side: edges of the synchronized clock while selected
  assign s_sel   = en_q && !mst_q && !ss_s;
  assign s_start = s_sel && !s_sel_q;
  assign s_edge  = s_sel && s_sel_q && (sck_s != sck_s_q);
  assign s_lead  = (sck_s != cpol_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_sel_q <= 1'b0;
      sck_s_q <= 1'b0;
    end else begin
      s_sel_q <= s_sel;
      sck_s_q <= sck_s;
    end
  end

  assign edge_ev   = mst_q ? m_edge : s_edge;
  assign lead_ev   = mst_q ? m_lead : s_lead;
  assign sample_ev = edge_ev && (cpha_q ? !lead_ev : lead_ev);
  assign shift_ev  = edge_ev && (cpha_q ? lead_ev : !lead_ev);

  spi_shift #(.W(DW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (m_start || s_start),
    .tx_i      (m_start ? wdata_i : tx_hold_q),
    .lsb_i     (lsb_q),
    .sample_i  (sample_ev),
    .shift_i   (shift_ev),
    .sdi_i     (mst_q ? miso_s : mosi_s),
    .sdo_o     (sdo),
    .done_o    (shift_done),
    .rx_next_o (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; mst_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; lsb_q <= 1'b0;
      modf_en_q <= 1'b0; ssoe_q <= 1'b0; div_q <= '0;
      tx_hold_q <= '0; rx_buf_q <= '0; done_q <= 1'b0; modf_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == ADDR_CFG) begin
        en_q   <= wdata_i[0];
        mst_q  <= wdata_i[1];
        cpol_q <= wdata_i[2];
        cpha_q <= wdata_i[3];
        lsb_q  <= wdata_i[4];
      end
      if (wr_i && addr_i == ADDR_CFG2) begin
        modf_en_q <= wdata_i[0];
        ssoe_q    <= wdata_i[1];
        div_q     <= wdata_i[3 +: DIV_W];
      end
      if (wr_data) tx_hold_q <= wdata_i;
      if (shift_done) begin
        rx_buf_q <= rx_next;
        done_q   <= 1'b1;
      end else if (rd_data) begin
        done_q <= 1'b0;
      end
      if (modf_hit) begin
        modf_q <= 1'b1;
        mst_q  <= 1'b0;
      end else if (wr_i && addr_i == ADDR_STAT && wdata_i[5]) begin
        modf_q <= 1'b0;
      end
    end
  end

  assign busy = m_active || s_sel;

  always_comb begin
    unique case (addr_i)
      ADDR_CFG:  rdata_o = {3'b000, lsb_q, cpha_q, cpol_q, mst_q, en_q};
      ADDR_CFG2: rdata_o = {3'b000, div_q, 1'b0, ssoe_q, modf_en_q};
      ADDR_DATA: rdata_o = rx_buf_q;
      default:   rdata_o = {done_q, 1'b0, modf_q, 4'b0000, busy};
    endcase
  end

  assign sck_o     = cpol_q ^ m_phase;
  assign sck_oe_o  = en_q && mst_q;
  assign mosi_o    = sdo;
  assign mosi_oe_o = en_q && mst_q;
  assign miso_o    = sdo;
  assign miso_oe_o = s_sel;
  assign ss_o      = !m_active;
  assign ss_oe_o   = en_q && mst_q && modf_en_q && ssoe_q;

  AST_PIN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_oe_o && miso_oe_o)); // R9
  AST_MODF_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_hit |=> (!mst_q && modf_q && !sck_oe_o)); // R8
  AST_SS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_oe_o && m_edge) |-> !ss_o); // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rd_data) |=> done_q); // R11
endmodule

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] addr_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;
  logic miso_i;
  logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, ss_o, ss_oe_o;

  spi_xcvr u_spi_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe_o(ss_oe_o)
  );

  int total = 0, bad = 0;

  // bench-side slave model for master transfers (written only here)
  logic m_cpol, m_cpha, m_lsb, m_chk_ss, mdl_clr = 1'b0;
  logic [7:0] m_md, m_sd, m_rx;
  int m_cnt, m_oidx, m_edges, m_gap, m_gap_bad, m_bit_bad, m_ss_bad, exp_half;
  logic sck_prev, ss_prev;

  initial begin
    m_cpol = 0; m_cpha = 0; m_lsb = 0; m_chk_ss = 0; m_md = 0; m_sd = 0; exp_half = 4;
  end

  assign miso_i = m_sd[m_lsb ? m_oidx[2:0] : 3'(7 - m_oidx)];

  always @(negedge clk) begin
    if (mdl_clr) begin
      m_cnt = 0; m_oidx = 0; m_rx = '0; m_edges = 0; m_gap = 0;
      m_gap_bad = 0; m_bit_bad = 0; m_ss_bad = 0;
      sck_prev = sck_o; ss_prev = ss_o;
    end else begin
      m_gap++;
      if (ss_prev && !ss_o) m_gap = 0;
      if (sck_o !== sck_prev) begin
        m_edges++;
        if (m_gap != exp_half) m_gap_bad++;
        m_gap = 0;
        if (m_chk_ss && ss_o) m_ss_bad++;
        if ((sck_o != m_cpol) != m_cpha) begin
          if (m_cnt < 8) begin
            if (mosi_o !== m_md[m_lsb ? m_cnt : 7 - m_cnt]) m_bit_bad++;
            m_rx[m_lsb ? m_cnt : 7 - m_cnt] = mosi_o;
            m_cnt++;
          end
        end else if (m_cnt > 0 && m_cnt < 8) begin
          m_oidx = m_cnt;
        end
      end
      sck_prev = sck_o; ss_prev = ss_o;
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    step();
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    step();
    rd_i = 1'b0;
  endtask

  function automatic logic bitk(input logic [7:0] d, input int k, input logic lsb);
    return lsb ? d[k] : d[7-k];
  endfunction

  task automatic run_master(input logic cpol, input logic cpha, input logic lsb,
                            input logic [1:0] div, input logic [7:0] md, input logic [7:0] sd,
                            input logic modf_en, input logic ssoe);
    logic [7:0] v;
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_md = md; m_sd = sd;
    m_chk_ss = modf_en & ssoe; exp_half = 4 << div;
    wr(2'd1, {3'b000, div, 1'b0, ssoe, modf_en});
    wr(2'd0, {3'b000, lsb, cpha, cpol, 1'b1, 1'b1});
    mdl_clr = 1'b1; step(); step(); mdl_clr = 1'b0;
    wr(2'd2, md);
    repeat (exp_half * 18 + 6) step();
    chk("R1 mosi byte seen by bench slave", m_rx, md);
    chk("R2 sck edge count", m_edges, 16);
    chk("R2 sck rest level", sck_o, cpol);
    chk("R3 bits valid at capture edges", m_bit_bad, 0);
    chk("R5 half-period spacing", m_gap_bad, 0);
    chk("R6 ss low across edges", m_ss_bad, 0);
    chk("R6 ss released", ss_o, 1'b1);
    rd(2'd3, v);
    chk("R11 done set", v[7], 1'b1);
    rd(2'd2, v);
    if (lsb) chk("R4 lsb-first receive", v, sd);
    else     chk("R1 miso byte received", v, sd);
    rd(2'd3, v);
    chk("R11 done cleared by data read", v[7], 1'b0);
  endtask

  task automatic run_slave(input logic cpol, input logic cpha, input logic lsb,
                           input logic [7:0] md, input logic [7:0] sd,
                           input logic modf_en, input logic ssoe);
    logic [7:0] v, rx;
    int cnt, oe_bad;
    rx = '0; cnt = 0; oe_bad = 0;
    wr(2'd1, {6'b0, ssoe, modf_en});
    wr(2'd0, {3'b000, lsb, cpha, cpol, 1'b0, 1'b1});
    wr(2'd2, sd);
    sck_i = cpol;
    repeat (4) step();
    ss_i = 1'b0;
    if (!cpha) mosi_i = bitk(md, 0, lsb);
    repeat (8) step();
    for (int e = 0; e < 16; e++) begin
      sck_i = ~sck_i;
      if ((e % 2 == 0) != cpha) begin
        if (miso_oe_o !== 1'b1) oe_bad++;
        if (cnt < 8) begin
          rx[lsb ? cnt : 7 - cnt] = miso_o;
          cnt++;
        end
      end else if (cnt < 8) begin
        mosi_i = bitk(md, cnt, lsb);
      end
      repeat (8) step();
    end
    chk("R9 sck output disabled in slave", sck_oe_o, 1'b0);
    ss_i = 1'b1;
    repeat (6) step();
    chk("R9 miso released when deselected", miso_oe_o, 1'b0);
    chk("R9 miso driven while selected", oe_bad, 0);
    chk("R9 slave sent data byte", rx, sd);
    rd(2'd2, v);
    chk("R9 slave received mosi byte", v, md);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    step();

    // R10 reset state and unimplemented bits
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R10 reset read", v, 8'h00);
    end
    chk("R10 reset enables", {sck_oe_o, mosi_oe_o, miso_oe_o, ss_oe_o}, 4'b0000);
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    chk("R10 CFG2 unimplemented bits", v, 8'h1B);
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    chk("R10 CFG unimplemented bits", v, 8'h1F);
    chk("R6 select drive enabled", ss_oe_o, 1'b1);
    wr(2'd0, 8'h17);

    // master sweep over polarity, phase, order, divider
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] md, sd;
        md = 8'h5A ^ 8'(c * 29 + p * 83);
        sd = ~md ^ 8'(p * 17 + 3);
        run_master(c[0], c[1], c[2], 2'(c + p), md, sd, 1'b1, 1'b1);
      end
    end

    // R7 select pin as general-purpose I/O
    ss_i = 1'b0;
    run_master(1'b0, 1'b1, 1'b0, 2'd0, 8'hC3, 8'h3C, 1'b0, 1'b1);
    chk("R7 ss not driven", ss_oe_o, 1'b0);
    rd(2'd3, v);
    chk("R7 no fault from low ss", v[5], 1'b0);
    ss_i = 1'b1;

    // slave sweep, fault and drive bits varied to show they are ignored
    for (int c = 0; c < 8; c++) begin
      run_slave(c[0], c[1], c[2], 8'h96 ^ 8'(c * 41), 8'h2D ^ 8'(c * 13), c[0], c[1]);
    end

    // R8 mode fault, R12 clearing
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'hA1);
    repeat (4) step();
    rd(2'd3, v);
    chk("R11 busy during transfer", v[0], 1'b1);
    ss_i = 1'b0;
    repeat (5) step();
    rd(2'd3, v);
    chk("R8 fault flag set", v[5], 1'b1);
    rd(2'd0, v);
    chk("R8 master bit cleared", v[1], 1'b0);
    chk("R8 outputs released", {sck_oe_o, mosi_oe_o}, 2'b00);
    ss_i = 1'b1;
    repeat (4) step();
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    chk("R12 fault kept on zero write", v[5], 1'b1);
    wr(2'd3, 8'h20);
    rd(2'd3, v);
    chk("R12 fault cleared", v[5], 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule